// File: doc/BRIEF.md
# Split-Transaction Bus Phase Sequencer

This block carries a single bus transaction from a local agent's request to its completion. The transaction moves through four phases in a fixed order: request, snoop, response and data. No error phase sits between request and snoop.

A local agent presents a read or write, an address and a byte length. The sequencer accepts the request when it is idle and the length fits. It then issues the request in one bus clock, as packet A and packet B, each with its own strobe. Next it waits out the snoop window and then for a response code. If data is to move, it hands a data job to a separate data-path engine. It finishes by pulsing a done output that carries status.

Interrupt messages travel as ordinary memory writes through the same phases. Only one transaction is in flight at a time.

Top module: `txn_phase_seq`

## Requirements
- R1: While idle, a request with length at most 64 bytes (64 included) is granted in the same cycle it is presented. After reset all outputs are low.
- R2: A request longer than 64 bytes raises the reject output instead of grant. The sequencer stays idle and no strobe follows.
- R3: The request phase lasts exactly one cycle, namely the cycle after the grant. In that cycle both strobes are high. Packet A carries {write bit, address}. Packet B carries the byte length.
- R4: The snoop phase directly follows the request phase. While the stall input is high the sequencer stays in snoop and ignores the response inputs. The hit input is captured in the first snoop cycle with stall low.
- R5: The response phase waits until rsp_valid is high. Code 3'b001 (retry) sends the transaction back to the request phase in the next cycle, with the same packets.
- R6: Code 3'b010 (error) completes the transaction in the next cycle with done_err high. In that same cycle, and only then, mce is high for one cycle.
- R7: Any other code with length zero completes the transaction in the next cycle without a data job.
- R8: Any other code with a nonzero length pulses dp_start for one cycle in the next cycle, with dp_len and dp_write. Done follows in the cycle after dp_done is seen.
- R9: Done is a one-cycle pulse carrying the captured hit. No further grant is given between a grant and its done.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low synchronous reset |
| lreq_valid | input | 1 | local request present |
| lreq_write | input | 1 | 1 = write, 0 = read |
| lreq_addr | input | AW | request address |
| lreq_len | input | LW | byte count |
| lreq_grant | output | 1 | request accepted |
| lreq_reject | output | 1 | request refused (too long) |
| req_pkt_a | output | AW+1 | packet A: {write, address} |
| req_pkt_b | output | LW | packet B: length |
| req_stb | output | 2 | strobes for packet A (bit 0) and B (bit 1) |
| snp_hit | input | 1 | snoop hit |
| snp_stall | input | 1 | extend snoop window |
| rsp_valid | input | 1 | response code present |
| rsp_code | input | 3 | response code |
| dp_start | output | 1 | data job start pulse |
| dp_len | output | DLW | data job byte count |
| dp_write | output | 1 | data job direction |
| dp_done | input | 1 | data engine finished |
| done | output | 1 | transaction complete pulse |
| done_err | output | 1 | completed with error |
| done_hit | output | 1 | snoop hit of completed transaction |
| mce | output | 1 | machine-check error pulse |

## Verification
The embedded properties assume three things about the inputs. rsp_code is known whenever rsp_valid is high. dp_done comes only from an engine that has been started. The reset is applied before the first request.

The stimulus drives all inputs at the falling edge and samples the outputs shortly after it. During stalled snoop cycles it deliberately holds rsp_valid high with the error code and flips the hit value, so that ignoring those inputs is observable. It raises dp_done only while a data job is pending, and it keeps offering new requests while a transaction is still in flight.

// File: rtl/txn_phase_seq.sv
module txn_phase_seq #(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int MAX_BYTES = 64,
  localparam int DLW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreq_valid,
  input  logic          lreq_write,
  input  logic [AW-1:0] lreq_addr,
  input  logic [LW-1:0] lreq_len,
  output logic          lreq_grant,
  output logic          lreq_reject,
  output logic [AW:0]   req_pkt_a,
  output logic [LW-1:0] req_pkt_b,
  output logic [1:0]    req_stb,
  input  logic          snp_hit,
  input  logic          snp_stall,
  input  logic          rsp_valid,
  input  logic [2:0]    rsp_code,
  output logic          dp_start,
  output logic [DLW-1:0] dp_len,
  output logic          dp_write,
  input  logic          dp_done,
  output logic          done,
  output logic          done_err,
  output logic          done_hit,
  output logic          mce
);

  localparam logic [2:0] CODE_RETRY = 3'b001;
  localparam logic [2:0] CODE_ERR   = 3'b010;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_SNP, S_RSP, S_DGO, S_DWT, S_FIN
  } phase_t;

  phase_t        st;
  logic          w_q, hit_q, err_q;
  logic [AW-1:0] a_q;
  logic [LW-1:0] l_q;
  logic          too_big;

  assign too_big     = lreq_len > LW'(MAX_BYTES);
  assign lreq_grant  = (st == S_IDLE) && lreq_valid && !too_big;
  assign lreq_reject = (st == S_IDLE) && lreq_valid && too_big;

  assign req_stb   = {2{st == S_REQ}};
  assign req_pkt_a = (st == S_REQ) ? {w_q, a_q} : '0;
  assign req_pkt_b = (st == S_REQ) ? l_q : '0;

  assign dp_start = (st == S_DGO);
  assign dp_len   = dp_start ? DLW'(l_q) : '0;
  assign dp_write = dp_start & w_q;

  assign done     = (st == S_FIN);
  assign done_err = done & err_q;
  assign done_hit = done & hit_q;
  assign mce      = done & err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      w_q   <= 1'b0;
      a_q   <= '0;
      l_q   <= '0;
      hit_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (lreq_grant) begin
          w_q   <= lreq_write;
          a_q   <= lreq_addr;
          l_q   <= lreq_len;
          hit_q <= 1'b0;
          err_q <= 1'b0;
          st    <= S_REQ;
        end
        S_REQ: st <= S_SNP;
        S_SNP: if (!snp_stall) begin
          hit_q <= snp_hit;
          st    <= S_RSP;
        end
        S_RSP: if (rsp_valid) begin
          if (rsp_code == CODE_RETRY)    st <= S_REQ;
          else if (rsp_code == CODE_ERR) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end
          else if (l_q == '0)            st <= S_FIN;
          else                           st <= S_DGO;
        end
        S_DGO: st <= S_DWT;
        S_DWT: if (dp_done) st <= S_FIN;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  grant_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_grant |=> (req_stb == 2'b11));

  // R2
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_reject |=> (req_stb == 2'b00));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb[0] |=> !req_stb[0]);

  // R6
  mce_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mce |-> ($past(rsp_valid) && $past(rsp_code) == CODE_ERR));

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |=> (!dp_start && !done));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !mce));

endmodule

// File: tb/test_txn_phase_seq.sv
module test_txn_phase_seq;
  localparam int AW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lreq_valid = 1'b0, lreq_write = 1'b0;
  logic [AW-1:0] lreq_addr = '0;
  logic [LW-1:0] lreq_len = '0;
  logic          lreq_grant, lreq_reject;
  logic [AW:0]   req_pkt_a;
  logic [LW-1:0] req_pkt_b;
  logic [1:0]    req_stb;
  logic          snp_hit = 1'b0, snp_stall = 1'b0;
  logic          rsp_valid = 1'b0;
  logic [2:0]    rsp_code = '0;
  logic          dp_start, dp_write;
  logic [6:0]    dp_len;
  logic          dp_done = 1'b0;
  logic          done, done_err, done_hit, mce;

  int nvec = 0;
  int nerr = 0;
  logic [1:0] exp_q[$];

  always #10 clk = ~clk;

  txn_phase_seq #(.AW(AW), .LW(LW), .MAX_BYTES(64)) i_txn_phase_seq (
    .clk, .rst_n, .lreq_valid, .lreq_write, .lreq_addr, .lreq_len,
    .lreq_grant, .lreq_reject, .req_pkt_a, .req_pkt_b, .req_stb,
    .snp_hit, .snp_stall, .rsp_valid, .rsp_code,
    .dp_start, .dp_len, .dp_write, .dp_done,
    .done, .done_err, .done_hit, .mce);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && done) begin
      logic [1:0] e;
      if (exp_q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk({done_err, done_hit} == e, "R9 done status", {done_err, done_hit}, e);
      end
    end
  end

  task automatic run_txn(input logic w, input logic [AW-1:0] a, input int len,
                         input int stalls, input logic hit, input int retries,
                         input bit err, input logic [2:0] ok_code, input int dwait);
    @(negedge clk);
    lreq_valid = 1'b1; lreq_write = w; lreq_addr = a; lreq_len = LW'(len);
    #1;
    if (len > 64) begin
      chk(lreq_reject && !lreq_grant, "R2 reject", {lreq_reject, lreq_grant}, 2'b10);
      @(negedge clk); lreq_valid = 1'b0; #1;
      chk(req_stb == 2'b00, "R2 no strobe", req_stb, 0);
      return;
    end
    chk(lreq_grant && !lreq_reject, "R1 grant", {lreq_grant, lreq_reject}, 2'b10);
    for (int r = 0; r <= retries; r++) begin
      @(negedge clk); lreq_valid = 1'b0; rsp_valid = 1'b0; #1;
      chk(req_stb == 2'b11, "R3 strobes", req_stb, 3);
      chk(req_pkt_a == {w, a}, "R3 packet A", req_pkt_a, {w, a});
      chk(req_pkt_b == LW'(len), "R3 packet B", req_pkt_b, len);
      for (int s = 0; s < stalls; s++) begin
        @(negedge clk);
        snp_stall = 1'b1; snp_hit = ~hit; rsp_valid = 1'b1; rsp_code = 3'b010;
        lreq_valid = 1'b1; lreq_len = 8'd4; #1;
        chk(req_stb == 2'b00 && !done, "R4 stall hold", {req_stb, done}, 0);
        chk(!lreq_grant, "R9 no second grant", lreq_grant, 0);
      end
      @(negedge clk);
      snp_stall = 1'b0; snp_hit = hit; rsp_valid = 1'b0; lreq_valid = 1'b0; #1;
      chk(req_stb == 2'b00 && !done, "R4 snoop", {req_stb, done}, 0);
      @(negedge clk); snp_hit = ~hit; #1;
      chk(!done && !dp_start, "R5 wait response", {done, dp_start}, 0);
      @(negedge clk);
      rsp_valid = 1'b1;
      rsp_code = (r < retries) ? 3'b001 : (err ? 3'b010 : ok_code);
      #1;
      chk(!done, "R5 response", done, 0);
    end
    if (err || len == 0) begin
      exp_q.push_back({err, hit});
      @(negedge clk); rsp_valid = 1'b0; #1;
      chk(mce == err, err ? "R6 mce" : "R7 no mce", mce, err);
      chk(!dp_start, "R7 no data job", dp_start, 0);
      @(negedge clk); #1;
      chk(!mce && !done, "R6 mce one cycle", {mce, done}, 0);
    end else begin
      @(negedge clk); rsp_valid = 1'b0; #1;
      chk(dp_start && dp_len == 7'(len) && dp_write == w, "R8 data job",
          {dp_start, dp_len, dp_write}, {1'b1, 7'(len), w});
      for (int d = 0; d < dwait; d++) begin
        @(negedge clk); #1;
        chk(!done && !dp_start, "R8 wait engine", {done, dp_start}, 0);
      end
      @(negedge clk); dp_done = 1'b1; exp_q.push_back({1'b0, hit}); #1;
      @(negedge clk); dp_done = 1'b0; #1;
      chk(done, "R8 done after engine", done, 1);
      @(negedge clk); #1;
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        #1;
        chk({lreq_grant, lreq_reject, req_stb, dp_start, done, mce} == 0, "R1 reset",
            {lreq_grant, lreq_reject, req_stb, dp_start, done, mce}, 0);
        @(negedge clk); rst_n = 1'b1;
        run_txn(1'b1, 32'h1000_0040, 32, 0, 1'b1, 0, 0, 3'b000, 2);
        run_txn(1'b0, 32'hdead_bee0, 64, 3, 1'b0, 0, 0, 3'b111, 0);
        run_txn(1'b0, 32'h0000_0100, 65, 0, 1'b0, 0, 0, 3'b000, 0);
        run_txn(1'b1, 32'h0000_0200, 200, 0, 1'b0, 0, 0, 3'b000, 0);
        run_txn(1'b1, 32'hfee0_0000, 0, 1, 1'b1, 0, 0, 3'b100, 0);
        run_txn(1'b0, 32'h0000_3000, 16, 2, 1'b1, 2, 0, 3'b000, 1);
        run_txn(1'b1, 32'h0000_4000, 8, 0, 1'b0, 0, 1, 3'b000, 0);
        run_txn(1'b0, 32'h0000_5000, 1, 1, 1'b1, 1, 1, 3'b000, 0);
        run_txn(1'b1, 32'h0000_6000, 1, 0, 1'b0, 0, 0, 3'b011, 0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all done seen", exp_q.size(), 0);
      end
      begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 1, 0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule